// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general-purpose registers of a processor whose register names resolve to different physical storage according to the processor mode. Registers r0 to r7 and r15 are one physical set seen from every mode. Every mode has its own r13 (stack pointer) and r14 (link register). The fast-interrupt mode also has a private set of r8 to r12, so its handlers can use those registers without first saving the interrupted program's values.

There are two combinational read ports and one clocked write port. Each is addressed by a 4-bit register number together with its own 3-bit mode input. Because each port carries its own mode, an exception sequencer can write the link register of the mode being entered while a different mode is still current. Next to the general registers there is one saved-status register for each exception mode, with its own read port and write port. User mode has no saved-status register.

Top module: `banked_regfile`

## Requirements
- R1: Registers 0 to 7 are one physical set. A value written to register n (n < 8) in any mode reads back at register n in every mode.
- R2: Registers 8 to 12 are shared by every mode except fast interrupt (mode 1), which has its own copy of each. A write on one side does not change what the other side reads.
- R3: Registers 13 and 14 are banked per mode. User, fast interrupt, IRQ, supervisor, abort and undefined each have a private pair, and a write in one mode leaves the pairs of the other modes unchanged.
- R4: Register 15 is one physical register shared by all modes.
- R5: Modes are encoded as 0 user, 1 fast interrupt, 2 IRQ, 3 supervisor, 4 abort, 5 undefined. Codes 6 and 7 act exactly like user mode on every port.
- R6: A write takes effect at the rising clock edge. A read of the entry being written in the same cycle returns the value held before the write.
- R7: The two read ports are independent. Each resolves its own register number under its own mode input, and both can read in the same cycle.
- R8: Modes 1 to 5 each have one saved-status register. A saved-status write with a given mode updates only that mode's register at the clock edge, and the read port returns the register selected by its own mode input.
- R9: A saved-status access with a user-mode code (0, 6 or 7) reads as zero, and a write with such a code changes nothing.
- R10: An active-low asynchronous reset clears every physical register, general and saved-status, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_mode | input | 3 | Read port A mode |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_mode | input | 3 | Read port B mode |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable for the general registers |
| wr_idx | input | 4 | Write register number |
| wr_mode | input | 3 | Write mode |
| wr_data | input | DATA_W | Write data |
| sr_rd_mode | input | 3 | Saved-status read mode |
| sr_rd_data | output | DATA_W | Saved-status read data |
| sr_wr_en | input | 1 | Saved-status write enable |
| sr_wr_mode | input | 3 | Saved-status write mode |
| sr_wr_data | input | DATA_W | Saved-status write data |

## Verification
A wrong bank mapping shows up as a value that appears in a mode where it should not, or as a value missing from a mode where it should appear. Both read paths are combinational, so the error is visible on the read ports in the cycle straight after the offending write. The bench writes a distinct value into every register number under all eight mode codes. After each single write it reads every register number under every mode code on both ports, so a misrouted write is found immediately and traced to one write. The saved-status registers get the same sweep, which catches a user-mode code that reaches storage or an exception mode that shares a register with another mode.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  input  logic [2:0]        rd_a_mode,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  input  logic [2:0]        rd_b_mode,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [2:0]        wr_mode,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        sr_rd_mode,
  output logic [DATA_W-1:0] sr_rd_data,
  input  logic              sr_wr_en,
  input  logic [2:0]        sr_wr_mode,
  input  logic [DATA_W-1:0] sr_wr_data
);
  localparam int NMODES  = 6;
  localparam int NLOW    = 8;
  localparam int NHIGH   = 5;
  localparam int FIQ_OFS = NLOW + NHIGH;
  localparam int SP_OFS  = FIQ_OFS + NHIGH;
  localparam int PC_SLOT = SP_OFS + 2 * NMODES;
  localparam int NPHYS   = PC_SLOT + 1;
  localparam int NSAVED  = NMODES - 1;

  logic [DATA_W-1:0] gpr [NPHYS];
  logic [DATA_W-1:0] spsr [NSAVED];

  function automatic logic [2:0] fold(input logic [2:0] mode);
    return (mode > 3'd5) ? 3'd0 : mode;
  endfunction

  function automatic logic [4:0] slot(input logic [3:0] idx, input logic [2:0] mode);
    logic [2:0] m;
    m = fold(mode);
    if (idx < 4'd8)
      return 5'(idx);
    else if (idx < 4'd13)
      return (m == 3'd1) ? 5'(idx) + 5'(NHIGH) : 5'(idx);
    else if (idx < 4'd15)
      return 5'(SP_OFS) + 5'({m, 1'b0}) + 5'(idx - 4'd13);
    else
      return 5'(PC_SLOT);
  endfunction

  logic [4:0] a_slot, b_slot, w_slot;
  logic [2:0] sr_r, sr_w;

  assign a_slot = slot(rd_a_idx, rd_a_mode);
  assign b_slot = slot(rd_b_idx, rd_b_mode);
  assign w_slot = slot(wr_idx, wr_mode);
  assign sr_r   = fold(sr_rd_mode);
  assign sr_w   = fold(sr_wr_mode);

  assign rd_a_data  = gpr[a_slot];
  assign rd_b_data  = gpr[b_slot];
  assign sr_rd_data = (sr_r == 3'd0) ? '0 : spsr[sr_r - 3'd1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) gpr[i] <= '0;
    end else if (wr_en) begin
      gpr[w_slot] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSAVED; i++) spsr[i] <= '0;
    end else if (sr_wr_en && sr_w != 3'd0) begin
      spsr[sr_w - 3'd1] <= sr_wr_data;
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        rd_a_idx,
  input logic [2:0]        rd_a_mode,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [2:0]        rd_b_mode,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [2:0]        wr_mode,
  input logic [DATA_W-1:0] wr_data,
  input logic [2:0]        sr_rd_mode,
  input logic [DATA_W-1:0] sr_rd_data,
  input logic              sr_wr_en,
  input logic [2:0]        sr_wr_mode,
  input logic [DATA_W-1:0] sr_wr_data
);
  logic [2:0] b_mode_n, w_mode_n;
  assign b_mode_n = (rd_b_mode > 3'd5) ? 3'd0 : rd_b_mode;
  assign w_mode_n = (wr_mode > 3'd5) ? 3'd0 : wr_mode;

  a_r1_low_shared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_idx) < 4'd8 && rd_a_idx == $past(wr_idx))
    |-> rd_a_data == $past(wr_data));

  a_r4_pc_shared: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_idx) == 4'd15 && rd_b_idx == 4'd15)
    |-> rd_b_data == $past(wr_data));

  a_r2_fiq_private: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_mode) == 3'd1 && $past(wr_idx) >= 4'd8 && $past(wr_idx) <= 4'd12
     && rd_a_mode != 3'd1 && $stable(rd_a_mode) && $stable(rd_a_idx)
     && rd_a_idx >= 4'd8 && rd_a_idx <= 4'd12)
    |-> $stable(rd_a_data));

  a_r3_sp_lr_banked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_idx) >= 4'd13 && $past(wr_idx) <= 4'd14
     && $past(w_mode_n) != b_mode_n && $stable(rd_b_mode) && $stable(rd_b_idx))
    |-> $stable(rd_b_data));

  a_r8_saved_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sr_wr_en) && $past(sr_wr_mode) >= 3'd1 && $past(sr_wr_mode) <= 3'd5
     && sr_rd_mode == $past(sr_wr_mode))
    |-> sr_rd_data == $past(sr_wr_data));

  a_r9_user_saved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd_mode == 3'd0 || sr_rd_mode > 3'd5) |-> sr_rd_data == '0);

  a_r9_user_saved_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sr_wr_en) && ($past(sr_wr_mode) == 3'd0 || $past(sr_wr_mode) > 3'd5)
     && $stable(sr_rd_mode))
    |-> $stable(sr_rd_data));

  a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_a_data == '0 && rd_b_data == '0 && sr_rd_data == '0));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_mode(rd_b_mode), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode), .wr_data(wr_data),
  .sr_rd_mode(sr_rd_mode), .sr_rd_data(sr_rd_data),
  .sr_wr_en(sr_wr_en), .sr_wr_mode(sr_wr_mode), .sr_wr_data(sr_wr_data)
);

// File: tb/tb_banked_regfile.sv
`timescale 1ns/100ps
module tb_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [2:0]  rd_a_mode = '0, rd_b_mode = '0, wr_mode = '0;
  logic [2:0]  sr_rd_mode = '0, sr_wr_mode = '0;
  logic        wr_en = 1'b0, sr_wr_en = 1'b0;
  logic [31:0] wr_data = '0, sr_wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data, sr_rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mdl [0:5][0:15];
  logic [31:0] msr [0:5];

  always #2.5 clk = ~clk;

  banked_regfile #(.DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_mode(rd_b_mode), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode), .wr_data(wr_data),
    .sr_rd_mode(sr_rd_mode), .sr_rd_data(sr_rd_data),
    .sr_wr_en(sr_wr_en), .sr_wr_mode(sr_wr_mode), .sr_wr_data(sr_wr_data)
  );

  function automatic int nm(input int m);
    return (m > 5) ? 0 : m;
  endfunction

  function automatic string tag_of(input int i, input int m);
    if (m > 5) return "R5";
    if (i < 8) return "R1";
    if (i < 13) return "R2";
    if (i < 15) return "R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int m = 0; m < 6; m++) begin
      msr[m] = '0;
      for (int i = 0; i < 16; i++) mdl[m][i] = '0;
    end
  endtask

  task automatic model_write(input int i, input int wm, input logic [31:0] d);
    for (int m = 0; m < 6; m++) begin
      bit hit;
      if (i < 8 || i == 15) hit = 1;
      else if (i < 13) hit = ((m == 1) == (nm(wm) == 1));
      else hit = (m == nm(wm));
      if (hit) mdl[m][i] = d;
    end
  endtask

  task automatic read_all(input string ctx);
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 16; i++) begin
        rd_a_idx = 4'(i); rd_a_mode = 3'(m);
        rd_b_idx = 4'(15 - i); rd_b_mode = 3'(7 - m);
        #0.1;
        check(tag_of(i, m), $sformatf("%s port A r%0d mode %0d", ctx, i, m), rd_a_data, mdl[nm(m)][i]);
        check("R7", $sformatf("%s port B r%0d mode %0d", ctx, 15 - i, 7 - m), rd_b_data, mdl[nm(7 - m)][15 - i]);
      end
    end
  endtask

  task automatic sr_read_all(input string ctx);
    for (int m = 0; m < 8; m++) begin
      sr_rd_mode = 3'(m);
      #0.1;
      check((nm(m) == 0) ? "R9" : "R8", $sformatf("%s saved mode %0d", ctx, m), sr_rd_data, msr[nm(m)]);
    end
  endtask

  task automatic do_write(input int i, input int wm, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(i); wr_mode = 3'(wm); wr_data = d;
    rd_a_idx = 4'(i); rd_a_mode = 3'(wm);
    #0.1;
    check("R6", $sformatf("old value r%0d mode %0d", i, wm), rd_a_data, mdl[nm(wm)][i]);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(i, wm, d);
  endtask

  task automatic do_sr_write(input int wm, input logic [31:0] d);
    @(negedge clk);
    sr_wr_en = 1'b1; sr_wr_mode = 3'(wm); sr_wr_data = d;
    sr_rd_mode = 3'(wm);
    #0.1;
    check("R6", $sformatf("saved old value mode %0d", wm), sr_rd_data, msr[nm(wm)]);
    @(negedge clk);
    sr_wr_en = 1'b0;
    if (nm(wm) != 0) msr[wm] = d;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    read_all("R10 reset");
    sr_read_all("R10 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    read_all("R10 reset");
    sr_read_all("R10 reset");
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int wm = 0; wm < 8; wm++) begin
        for (int i = 0; i < 16; i++) begin
          do_write(i, wm, {8'(p + 1), 8'(wm), 8'(i), 8'h5A} ^ 32'(p * 32'h00F0_0F00));
          read_all($sformatf("after w r%0d m%0d", i, wm));
        end
      end
    end
    for (int p = 0; p < 2; p++) begin
      for (int wm = 0; wm < 8; wm++) begin
        do_sr_write(wm, {8'hC3, 8'(p), 8'(wm), 8'h17});
        sr_read_all($sformatf("after saved w m%0d", wm));
      end
    end
    apply_reset();
    do_write(13, 2, 32'hDEAD_0013);
    do_sr_write(4, 32'h0000_00D4);
    read_all("post reset");
    sr_read_all("post reset");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule